// File: doc/BRIEF.md
# Fast page mode DRAM controller

This block sits between a simple synchronous request port and an asynchronous byte-wide DRAM that has multiplexed address pins. Each request carries a 21-bit word address, a write flag and a byte of write data. The block splits the address into an 11-bit row and a 10-bit column. It opens the row with a row strobe, then runs the access with a column strobe. Read data comes back on a one-cycle response pulse.

After an access, the row is left open. A later request to the same row is a page hit: it needs only a new column address and a new column strobe. Reads and writes may follow each other in any column order inside the open page. A request to another row first closes the page and waits out a precharge time. Every strobe width is counted in clocks and set by parameters.

A refresh timer asks for a refresh at a fixed interval. When a refresh is due, the open row is closed. The block then runs one refresh cycle in which the column strobe falls before the row strobe. New requests are taken only after this cycle ends.

The data bus is brought out as three signals: an output value, an output enable and an input value, which the pad ring combines into a tri-state bus.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row part is `req_addr[20:10]` and appears on `dram_addr` when `dram_ras_n` falls. The column part is `req_addr[9:0]`, zero-extended to 11 bits, and appears on `dram_addr` when `dram_cas_n` falls.
- R2: `dram_addr` holds the same value in the cycle before and the cycle of each `dram_ras_n` fall. `dram_addr` and `dram_we_n` hold the same value in the cycle before and the cycle of each `dram_cas_n` fall.
- R3: A write drives `dram_we_n` low, `dq_oe` high and `dq_out` with the write data before `dram_cas_n` falls, so the write is an early write. `dram_oe_n` stays high while the column strobe is low.
- R4: A read keeps `dram_we_n` high and drops `dram_oe_n` together with `dram_cas_n`. After T_CAS clocks with the column strobe low, the block samples `dq_in` into `rsp_rdata`, pulses `rsp_valid` high for one cycle and raises `dram_cas_n`. Writes produce no response pulse.
- R5: A request to the open row keeps `dram_ras_n` low and issues only a column strobe. For such a read, `rsp_valid` is high T_CAS+1 clock edges after the accepting edge.
- R6: Inside one open page, columns may be accessed in any order and reads and writes may alternate. Each read returns the byte most recently written to that address, or 0 for a location never written.
- R7: A request to a different row raises `dram_ras_n` for T_RP clocks before the new row strobe; the response latency is T_RP+T_RCD+T_CAS+2 edges. With no row open, it is T_RCD+T_CAS+2 edges.
- R8: Every REF_INTERVAL clocks a refresh is due. The open row is closed, `dram_cas_n` falls while `dram_ras_n` is high, then `dram_ras_n` stays low for T_RAS clocks. Both strobes then rise and a precharge follows. The next request finds no row open.
- R9: `req_ready` is low while any access, precharge or refresh step is under way, and while a refresh is due. When `req_ready` is high, the column strobe, write enable and output enable are all high and `dq_oe` is low.
- R10: In reset, all four strobes are high (inactive), `dq_oe` and `rsp_valid` are low, and `req_ready` is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in the upper 11 bits |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dq_out | output | 8 | Data driven toward the DRAM |
| dq_oe | output | 1 | Enable for the data pad drivers |
| dq_in | input | 8 | Data received from the DRAM |

## Verification
A behavioural DRAM model in the bench decodes the strobes on every clock. It stores written bytes and checks the pin values against the request being served. Directed sequences try the three page cases, each with its own latency:
- a row that is already open (a hit),
- no open row,
- a different open row (a miss).

Writes then reads in descending column order test whether hits really stay in the page. Extreme rows and columns test the address split. A long pseudo-random mix of reads and writes over three rows, followed by a long idle period, shows whether refresh comes at the right rate and whether it correctly closes the page under the next access.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPEN,
        S_RSET,
        S_RCD,
        S_CSET,
        S_CAS,
        S_PRE,
        S_RFC,
        S_RFR
    } seq_state_e;

    typedef enum logic [1:0] {
        PT_IDLE,
        PT_ROW,
        PT_REF
    } pre_tgt_e;

endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
    parameter int ROW_W = 11,
    parameter int COL_W = 10,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              page_open,
    output logic [ROW_W-1:0]  row_pins,
    output logic [ROW_W-1:0]  col_pins,
    output logic              hit
);
    always_comb begin
        row_pins = req_addr[ADDR_W-1:COL_W];
        col_pins = ROW_W'(req_addr[COL_W-1:0]);
        hit      = page_open && (row_pins == open_row);
    end
endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int REF_INTERVAL = 1560,
    localparam int RW = $clog2(REF_INTERVAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pend
);
    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (ref_ack) begin
            tmr_d.pend = 1'b0;
        end
        if (tmr_q.cnt == '0) begin
            tmr_d.cnt  = RW'(REF_INTERVAL - 1);
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt  <= RW'(REF_INTERVAL - 1);
            tmr_q.pend <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign ref_pend = tmr_q.pend;

    // R8: a due refresh stays due until the sequencer takes it
    p_pend_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && !ref_ack) |=> ref_pend);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 10,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ROW_W-1:0]  row_pins,
    input  logic [ROW_W-1:0]  col_pins,
    input  logic              hit,
    input  logic              ref_pend,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ref_ack,
    output logic              req_ready,
    output logic [ROW_W-1:0]  open_row,
    output logic              page_open,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ROW_W-1:0]  addr_pins,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int T_M1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_M2  = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        pre_tgt_e          tgt;
        logic [CNT_W-1:0]  cnt;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              rsp_v;
        logic              wr;
        logic [ROW_W-1:0]  pins;
        logic [ROW_W-1:0]  open_row;
        logic [ROW_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic idle_like;

    assign idle_like = (seq_q.st == S_IDLE) || (seq_q.st == S_OPEN);
    assign req_ready = idle_like && !ref_pend;

    always_comb begin
        seq_d       = seq_q;
        seq_d.rsp_v = 1'b0;
        ref_ack     = 1'b0;
        unique case (seq_q.st)
            S_IDLE: begin
                if (ref_pend) begin
                    ref_ack     = 1'b1;
                    seq_d.cas_n = 1'b0;
                    seq_d.st    = S_RFC;
                end else if (req_valid) begin
                    seq_d.wr       = req_write;
                    seq_d.wdata    = req_wdata;
                    seq_d.col      = col_pins;
                    seq_d.open_row = row_pins;
                    seq_d.pins     = row_pins;
                    seq_d.st       = S_RSET;
                end
            end
            S_OPEN: begin
                if (ref_pend) begin
                    ref_ack     = 1'b1;
                    seq_d.ras_n = 1'b1;
                    seq_d.cnt   = CNT_W'(T_RP - 1);
                    seq_d.tgt   = PT_REF;
                    seq_d.st    = S_PRE;
                end else if (req_valid) begin
                    seq_d.wr    = req_write;
                    seq_d.wdata = req_wdata;
                    seq_d.col   = col_pins;
                    if (hit) begin
                        seq_d.pins  = col_pins;
                        seq_d.we_n  = ~req_write;
                        seq_d.dq_oe = req_write;
                        seq_d.st    = S_CSET;
                    end else begin
                        seq_d.open_row = row_pins;
                        seq_d.ras_n    = 1'b1;
                        seq_d.cnt      = CNT_W'(T_RP - 1);
                        seq_d.tgt      = PT_ROW;
                        seq_d.st       = S_PRE;
                    end
                end
            end
            S_RSET: begin
                seq_d.ras_n = 1'b0;
                seq_d.cnt   = CNT_W'(T_RCD - 1);
                seq_d.st    = S_RCD;
            end
            S_RCD: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.pins  = seq_q.col;
                    seq_d.we_n  = ~seq_q.wr;
                    seq_d.dq_oe = seq_q.wr;
                    seq_d.st    = S_CSET;
                end
            end
            S_CSET: begin
                seq_d.cas_n = 1'b0;
                seq_d.oe_n  = seq_q.wr;
                seq_d.cnt   = CNT_W'(T_CAS - 1);
                seq_d.st    = S_CAS;
            end
            S_CAS: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.cas_n = 1'b1;
                    seq_d.oe_n  = 1'b1;
                    seq_d.we_n  = 1'b1;
                    seq_d.dq_oe = 1'b0;
                    if (!seq_q.wr) begin
                        seq_d.rsp_v = 1'b1;
                        seq_d.rdata = dq_in;
                    end
                    seq_d.st = S_OPEN;
                end
            end
            S_PRE: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    unique case (seq_q.tgt)
                        PT_ROW: begin
                            seq_d.pins = seq_q.open_row;
                            seq_d.st   = S_RSET;
                        end
                        PT_REF: begin
                            seq_d.cas_n = 1'b0;
                            seq_d.st    = S_RFC;
                        end
                        default: seq_d.st = S_IDLE;
                    endcase
                end
            end
            S_RFC: begin
                seq_d.ras_n = 1'b0;
                seq_d.cnt   = CNT_W'(T_RAS - 1);
                seq_d.st    = S_RFR;
            end
            S_RFR: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.ras_n = 1'b1;
                    seq_d.cas_n = 1'b1;
                    seq_d.cnt   = CNT_W'(T_RP - 1);
                    seq_d.tgt   = PT_IDLE;
                    seq_d.st    = S_PRE;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q          <= '0;
            seq_q.st       <= S_IDLE;
            seq_q.tgt      <= PT_IDLE;
            seq_q.ras_n    <= 1'b1;
            seq_q.cas_n    <= 1'b1;
            seq_q.we_n     <= 1'b1;
            seq_q.oe_n     <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign open_row  = seq_q.open_row;
    assign page_open = (seq_q.st == S_OPEN);
    assign rsp_valid = seq_q.rsp_v;
    assign rsp_rdata = seq_q.rdata;
    assign ras_n     = seq_q.ras_n;
    assign cas_n     = seq_q.cas_n;
    assign we_n      = seq_q.we_n;
    assign oe_n      = seq_q.oe_n;
    assign addr_pins = seq_q.pins;
    assign dq_out    = seq_q.wdata;
    assign dq_oe     = seq_q.dq_oe;

    // R2: row address settled before the row strobe falls
    p_row_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(addr_pins));
    // R2: column address and write enable settled before the column strobe falls
    p_col_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($stable(addr_pins) && $stable(we_n)));
    // R3: early write keeps the DRAM output off and drives the bus
    p_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !we_n) |-> (oe_n && dq_oe));
    // R4: read response is a single-cycle pulse
    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R5: a page hit keeps the row strobe low
    p_hit_keeps_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=> !ras_n);
    // R7: row strobe stays high for more than one cycle after rising
    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    // R8: column-before-row refresh follows with the row strobe
    p_refresh_cbr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && ras_n) |=> (!cas_n && !ras_n));
    // R9: strobes quiet whenever a request can be taken
    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cas_n && we_n && oe_n && !dq_oe));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
    parameter int ROW_W        = 11,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int T_RAS        = 4,
    parameter int REF_INTERVAL = 1560,
    localparam int ADDR_W      = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    logic [ROW_W-1:0] row_pins, col_pins, open_row;
    logic             hit, page_open, ref_pend, ref_ack;

    fpm_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) i_split (
        .req_addr  (req_addr),
        .open_row  (open_row),
        .page_open (page_open),
        .row_pins  (row_pins),
        .col_pins  (col_pins),
        .hit       (hit)
    );

    fpm_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) i_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ack  (ref_ack),
        .ref_pend (ref_pend)
    );

    fpm_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .row_pins  (row_pins),
        .col_pins  (col_pins),
        .hit       (hit),
        .ref_pend  (ref_pend),
        .dq_in     (dq_in),
        .ref_ack   (ref_ack),
        .req_ready (req_ready),
        .open_row  (open_row),
        .page_open (page_open),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .addr_pins (dram_addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );
endmodule

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RP  = 3;
    localparam int T_RAS = 4;
    localparam int T_REF = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [10:0] dram_addr;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [7:0]  dq_in = 8'hEE;

    fpm_dram_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS),
        .REF_INTERVAL(T_REF)
    ) i_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural DRAM and expected contents
    logic [7:0]  dmem [int];
    logic [7:0]  emem [int];
    logic        p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    logic [10:0] p_addr = '0;
    logic [10:0] m_row = '0;
    logic [9:0]  m_col = '0;
    bit          row_valid = 1'b0;
    bit          in_ref = 1'b0;
    bit          seen_ras_rise = 1'b0;
    int          ras_high = 0, ras_low = 0;
    int          ras_falls = 0, refreshes = 0;
    logic [10:0] cur_row = '0;
    logic [9:0]  cur_col = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                if (!dram_cas_n) begin
                    in_ref = 1'b1;
                end else begin
                    chk(dram_addr == p_addr, "R2", "row addr setup", dram_addr, p_addr);
                    chk(dram_addr == cur_row, "R1", "row on pins", dram_addr, cur_row);
                    if (seen_ras_rise)
                        chk(ras_high >= T_RP, "R7", "precharge length", ras_high, T_RP);
                    m_row = dram_addr;
                    row_valid = 1'b1;
                    ras_falls++;
                end
            end
            if (p_cas && !dram_cas_n) begin
                chk(dram_addr == p_addr && dram_we_n == p_we, "R2", "col addr/we setup",
                    {dram_addr, dram_we_n}, {p_addr, p_we});
                if (dram_ras_n) begin
                    refreshes++;
                    chk(dram_we_n, "R8", "refresh with we high", dram_we_n, 1);
                end else begin
                    chk(dram_addr == {1'b0, cur_col}, "R1", "col on pins", dram_addr, {1'b0, cur_col});
                    m_col = dram_addr[9:0];
                    if (!dram_we_n) begin
                        chk(dq_oe && dram_oe_n, "R3", "early write bus/oe", {dq_oe, dram_oe_n}, 2'b11);
                        dmem[int'({m_row, m_col})] = dq_out;
                    end else begin
                        chk(!dram_oe_n && !dq_oe, "R4", "read oe low", {dram_oe_n, dq_oe}, 0);
                    end
                end
            end
            if (!p_ras && dram_ras_n) begin
                if (in_ref)
                    chk(ras_low == T_RAS, "R8", "refresh ras low length", ras_low, T_RAS);
                in_ref = 1'b0;
                row_valid = 1'b0;
                seen_ras_rise = 1'b1;
            end
            if (dram_ras_n) begin
                ras_high++;
                ras_low = 0;
            end else begin
                ras_low++;
                ras_high = 0;
            end
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n)
                dq_in = dmem.exists(int'({m_row, m_col})) ? dmem[int'({m_row, m_col})] : 8'h00;
            else
                dq_in = 8'hEE;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_we  = dram_we_n;
            p_addr = dram_addr;
        end
    end

    task automatic access(input bit wr, input logic [10:0] row, input logic [9:0] col,
                          input logic [7:0] d);
        int exp_lat;
        int n;
        string kind;
        int key;
        logic [7:0] expv;
        key = int'({row, col});
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (!dram_ras_n && row_valid && m_row == row) begin
            exp_lat = T_CAS + 1; kind = "R5";
        end else if (dram_ras_n) begin
            exp_lat = T_RCD + T_CAS + 2; kind = "R7";
        end else begin
            exp_lat = T_RP + T_RCD + T_CAS + 2; kind = "R7";
        end
        cur_row = row;
        cur_col = col;
        req_valid = 1'b1;
        req_write = wr;
        req_addr = {row, col};
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        if (wr) begin
            emem[key] = d;
            while (n < 200) begin
                @(negedge clk);
                n++;
                if (req_ready) break;
            end
            chk(n >= exp_lat, "R9", "ready low during write", n, exp_lat);
        end else begin
            expv = emem.exists(key) ? emem[key] : 8'h00;
            while (n < 200) begin
                @(negedge clk);
                n++;
                if (rsp_valid) break;
                if (req_ready) chk(0, "R9", "ready high mid-read", n, 0);
            end
            chk(n == exp_lat, kind, "read latency", n, exp_lat);
            chk(rsp_rdata == expv, "R6", "read data", rsp_rdata, expv);
            @(negedge clk);
            chk(!rsp_valid, "R4", "response single pulse", rsp_valid, 0);
        end
    endtask

    initial begin
        int falls0, refs0;
        logic [31:0] lfsr;
        logic [10:0] rows [3];
        rows[0] = 11'd3; rows[1] = 11'd700; rows[2] = 11'h7FF;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R10", "strobes idle in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!dq_oe && !rsp_valid, "R10", "bus off in reset", {dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R10", "ready after reset", req_ready, 1);
        chk(dram_cas_n && dram_we_n && dram_oe_n && !dq_oe, "R9", "quiet when ready",
            {dram_cas_n, dram_we_n, dram_oe_n, dq_oe}, 4'hE);

        // R1 / R7: closed page write, then hit read
        access(1, 11'd5, 10'd3, 8'h11);
        falls0 = ras_falls;
        access(0, 11'd5, 10'd3, 8'h00);
        chk(ras_falls == falls0, "R5", "no row strobe on hit", ras_falls, falls0);

        // R6: any column order, mixed read/write in page
        access(1, 11'd5, 10'd900, 8'hA1);
        access(1, 11'd5, 10'd17, 8'hB2);
        access(0, 11'd5, 10'd900, 8'h00);
        access(1, 11'd5, 10'd1, 8'hC3);
        access(0, 11'd5, 10'd17, 8'h00);
        access(0, 11'd5, 10'd1, 8'h00);
        access(0, 11'd5, 10'd2, 8'h00);
        chk(ras_falls == falls0, "R5", "page held across mixed accesses", ras_falls, falls0);

        // R1 boundaries, R7 page misses
        access(1, 11'h7FF, 10'h3FF, 8'h5A);
        access(1, 11'd0, 10'd0, 8'hA5);
        access(0, 11'h7FF, 10'h3FF, 8'h00);
        access(0, 11'd0, 10'd0, 8'h00);
        access(0, 11'd5, 10'd3, 8'h00);

        // mixed pseudo-random traffic over three rows
        lfsr = 32'hC0FFEE11;
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            access(lfsr[3], rows[lfsr[5:4] % 3], {7'd0, lfsr[10:8]}, lfsr[23:16]);
        end

        // R8 refresh rate while idle
        refs0 = refreshes;
        repeat (600) @(negedge clk);
        chk((refreshes - refs0) >= 3 && (refreshes - refs0) <= 5, "R8", "refresh count in 600 idle cycles",
            refreshes - refs0, 4);
        chk(dram_ras_n, "R8", "row closed after refresh", dram_ras_n, 1);
        access(0, 11'd700, 10'd0, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule